// File: doc/BRIEF.md
# Timer/Counter with Match and Capture Channels

A 32-bit timer/counter peripheral that sits behind a single-cycle register port. The counter advances either once per programmable number of clocks (a prescaler in front of it) or on chosen edges of one of four external capture inputs. Four match channels compare the counter against their own values. On a hit each one can flag an interrupt, wrap the counter to zero or halt it, and can set, clear or toggle its own external match output.

Four capture channels latch the counter value when their input shows a selected edge. Each capture input first goes through a two-flop synchronizer. All interrupt sources collect in one 8-bit flag register, and the single interrupt line is the OR of those flags. Software clears a flag by writing 1 to its bit.

Register words (5-bit word address): 0 flags, 1 control, 2 counter, 3 prescale limit, 4 prescale count, 5 match actions, 6..9 match values 0..3, 10 capture setup, 11..14 captured values 0..3 (read-only), 15 match-output register, 16 count source. Unmapped addresses read as zero.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `match_out` is 0.
- R2: With count source mode 0 (word 16 bits [1:0] = 0) and enable set, the prescale count rises by one on each clock. When it equals the prescale limit it returns to 0 and the counter steps once, so the counter advances once every limit+1 clocks.
- R3: Control word bit 0 enables counting. While bit 1 is set, the counter and prescale count are forced to zero, starting one clock after the write. With bit 0 clear and bit 1 clear, the counter holds its value.
- R4: Match action bit 3n+1 set: a count step taken while the counter equals match value n loads 0 instead of incrementing, so the count sequence has period value+1.
- R5: Match action bit 3n+2 set: a count step at match n leaves the counter unchanged and clears control bit 0.
- R6: Flag bits 0..3 belong to match channels and bits 4..7 to capture channels. A match flag is set only if match action bit 3n is set. `irq` is the OR of all flags. Writing 1 to a flag bit clears it, and writing 0xFF clears all of them.
- R7: Match-output register bits [3:0] are the `match_out` levels. Field [5+2n:4+2n] picks the action on a match of channel n: 0 keep, 1 drive low, 2 drive high, 3 toggle.
- R8: Capture setup bit 3n captures on a rising edge of `cap_in[n]`, and bit 3n+1 captures on a falling edge. A capture copies the counter into captured value n and sets flag 4+n only if bit 3n+2 is set. An edge whose type is not enabled changes nothing.
- R9: Count source mode 1, 2 or 3 steps the counter on rising, falling or both edges of `cap_in[k]`, where k is word 16 bits [3:2]. Edges on other inputs do not count.
- R10: Between bus writes to the counter, it only keeps its value, increments by one, or goes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Asynchronous capture / count inputs |
| match_out | output | 4 | External match output levels |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
The counting path is driven three ways: by the prescaled clock with a nonzero limit, by edges on the selected input in rising-only, falling-only and both-edge modes, and with pulses on a non-selected input. The results show that the divider ratio is right, that the edge type decodes correctly, and that the input select works. The match test places four channels at different values, each with a different output code, under one wrap-around. This separates keep, low, high and toggle, shows that flags of channels without the interrupt bit stay clear, and fixes how many wraps have occurred. The capture test uses a frozen counter and opposite edge polarities on two channels, so a capture on the wrong edge or a missing interrupt gate shows up as a wrong captured value or a wrong flag bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_W   = 32;
    localparam int unsigned TMR_NCH = 4;
    localparam int unsigned TMR_AW  = 5;
    localparam int unsigned TMR_NFL = 2 * TMR_NCH;

    localparam logic [TMR_AW-1:0] A_FLAGS = 5'd0;
    localparam logic [TMR_AW-1:0] A_CTRL  = 5'd1;
    localparam logic [TMR_AW-1:0] A_CNT   = 5'd2;
    localparam logic [TMR_AW-1:0] A_PLIM  = 5'd3;
    localparam logic [TMR_AW-1:0] A_PCNT  = 5'd4;
    localparam logic [TMR_AW-1:0] A_MACT  = 5'd5;
    localparam logic [TMR_AW-1:0] A_MVAL0 = 5'd6;
    localparam logic [TMR_AW-1:0] A_CSET  = 5'd10;
    localparam logic [TMR_AW-1:0] A_CVAL0 = 5'd11;
    localparam logic [TMR_AW-1:0] A_MOUT  = 5'd15;
    localparam logic [TMR_AW-1:0] A_SRC   = 5'd16;

    localparam logic [1:0] SRC_TIMER = 2'd0;

    typedef struct packed {
        logic [TMR_NFL-1:0]             flags;
        logic [1:0]                     ctrl;
        logic [TMR_W-1:0]               cnt;
        logic [TMR_W-1:0]               plim;
        logic [TMR_W-1:0]               pcnt;
        logic [3*TMR_NCH-1:0]           mact;
        logic [3*TMR_NCH-1:0]           cset;
        logic [TMR_NCH-1:0][TMR_W-1:0]  mval;
        logic [TMR_NCH-1:0][TMR_W-1:0]  cval;
        logic [TMR_NCH-1:0]             mlev;
        logic [2*TMR_NCH-1:0]           mcode;
        logic [3:0]                     src;
    } tmr_state_t;
endpackage

// File: rtl/tmr_cap_front.sv
module tmr_cap_front #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_in[g];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign rise[g] = s2_q & ~prev_q;
        assign fall[g] = ~s2_q & prev_q;
    end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 4
) (
    input  logic [W-1:0]        cnt,
    input  logic [N-1:0][W-1:0] val,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (cnt == val[g]);
    end
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    input  logic [TMR_NCH-1:0] cap_in,
    output logic [TMR_NCH-1:0] match_out,
    output logic              irq
);
    localparam int unsigned N = TMR_NCH;
    localparam int unsigned W = TMR_W;

    tmr_state_t st_d, st_q;

    logic [N-1:0]       rise, fall, hit, mhit;
    logic [TMR_NFL-1:0] set_v, clr_v;
    logic [1:0]         mode, sel;
    logic               run, step, any_rst, any_stop;

    // flat views for the bound checker
    logic [1:0]   ctrl_w;
    logic [3:0]   src_w;
    logic [W-1:0] cnt_w, pcnt_w, plim_w, cval0_w;

    tmr_cap_front #(.N(N)) u_front (
        .clk(clk), .rst_n(rst_n), .pin_in(cap_in), .rise(rise), .fall(fall)
    );

    tmr_match_unit #(.W(W), .N(N)) u_match (
        .cnt(st_q.cnt), .val(st_q.mval), .hit(hit)
    );

    always_comb begin
        st_d     = st_q;
        set_v    = '0;
        mode     = st_q.src[1:0];
        sel      = st_q.src[3:2];
        run      = st_q.ctrl[0] & ~st_q.ctrl[1];
        step     = 1'b0;
        any_rst  = 1'b0;
        any_stop = 1'b0;

        // count step generation
        if (mode == SRC_TIMER) begin
            if (run) begin
                if (st_q.pcnt == st_q.plim) begin
                    st_d.pcnt = '0;
                    step      = 1'b1;
                end else begin
                    st_d.pcnt = st_q.pcnt + 1'b1;
                end
            end
        end else begin
            step = run & ((mode[0] & rise[sel]) | (mode[1] & fall[sel]));
        end

        // match actions
        mhit = hit & {N{step}};
        for (int n = 0; n < N; n++) begin
            if (mhit[n]) begin
                if (st_q.mact[3*n])   set_v[n] = 1'b1;
                if (st_q.mact[3*n+1]) any_rst  = 1'b1;
                if (st_q.mact[3*n+2]) any_stop = 1'b1;
                case (st_q.mcode[2*n +: 2])
                    2'd1:    st_d.mlev[n] = 1'b0;
                    2'd2:    st_d.mlev[n] = 1'b1;
                    2'd3:    st_d.mlev[n] = ~st_q.mlev[n];
                    default: st_d.mlev[n] = st_q.mlev[n];
                endcase
            end
        end
        if (step) begin
            if (any_rst)       st_d.cnt = '0;
            else if (!any_stop) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (any_stop) st_d.ctrl[0] = 1'b0;

        // captures
        for (int n = 0; n < N; n++) begin
            if ((st_q.cset[3*n] & rise[n]) | (st_q.cset[3*n+1] & fall[n])) begin
                st_d.cval[n] = st_q.cnt;
                if (st_q.cset[3*n+2]) set_v[N+n] = 1'b1;
            end
        end

        // flags: hardware set wins over write-one-clear
        clr_v      = (bus_we && bus_addr == A_FLAGS) ? bus_wdata[TMR_NFL-1:0] : '0;
        st_d.flags = (st_q.flags & ~clr_v) | set_v;

        // bus writes override hardware updates
        if (bus_we) begin
            case (bus_addr)
                A_CTRL: st_d.ctrl  = bus_wdata[1:0];
                A_CNT:  st_d.cnt   = bus_wdata;
                A_PLIM: st_d.plim  = bus_wdata;
                A_PCNT: st_d.pcnt  = bus_wdata;
                A_MACT: st_d.mact  = bus_wdata[3*N-1:0];
                A_CSET: st_d.cset  = bus_wdata[3*N-1:0];
                A_MOUT: begin
                    st_d.mlev  = bus_wdata[N-1:0];
                    st_d.mcode = bus_wdata[3*N-1:N];
                end
                A_SRC:  st_d.src   = bus_wdata[3:0];
                default: ;
            endcase
            for (int n = 0; n < N; n++) begin
                if (bus_addr == A_MVAL0 + TMR_AW'(n)) st_d.mval[n] = bus_wdata;
            end
        end

        if (st_q.ctrl[1]) begin
            st_d.cnt  = '0;
            st_d.pcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FLAGS: bus_rdata = W'(st_q.flags);
            A_CTRL:  bus_rdata = W'(st_q.ctrl);
            A_CNT:   bus_rdata = st_q.cnt;
            A_PLIM:  bus_rdata = st_q.plim;
            A_PCNT:  bus_rdata = st_q.pcnt;
            A_MACT:  bus_rdata = W'(st_q.mact);
            A_CSET:  bus_rdata = W'(st_q.cset);
            A_MOUT:  bus_rdata = W'({st_q.mcode, st_q.mlev});
            A_SRC:   bus_rdata = W'(st_q.src);
            default: ;
        endcase
        for (int n = 0; n < N; n++) begin
            if (bus_addr == A_MVAL0 + TMR_AW'(n)) bus_rdata = st_q.mval[n];
            if (bus_addr == A_CVAL0 + TMR_AW'(n)) bus_rdata = st_q.cval[n];
        end
    end

    assign match_out = st_q.mlev;
    assign irq       = |st_q.flags;

    assign ctrl_w  = st_q.ctrl;
    assign src_w   = st_q.src;
    assign cnt_w   = st_q.cnt;
    assign pcnt_w  = st_q.pcnt;
    assign plim_w  = st_q.plim;
    assign cval0_w = st_q.cval[0];
endmodule

// File: rtl/tmr_mc_chk.sv
module tmr_mc_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [TMR_AW-1:0] bus_addr,
    input logic [1:0]        ctrl_q,
    input logic [3:0]        src_q,
    input logic [TMR_W-1:0]  cnt_q,
    input logic [TMR_W-1:0]  pcnt_q,
    input logic [TMR_W-1:0]  plim_q,
    input logic [TMR_W-1:0]  cval0_q
);
    logic cnt_wr;
    assign cnt_wr = bus_we && (bus_addr == A_CNT);

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> (cnt_q == '0 && pcnt_q == '0));

    // R3
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 2'b00 && !cnt_wr) |=> $stable(cnt_q));

    // R10
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

    // R2
    prescale_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_q[1:0] == SRC_TIMER && !cnt_wr && !ctrl_q[1])
         && cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(pcnt_q == plim_q));

    // R8
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cval0_q != $past(cval0_q)) |-> (cval0_q == $past(cnt_q)));
endmodule

bind tmr_match_capture tmr_mc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .ctrl_q(ctrl_w), .src_q(src_w), .cnt_q(cnt_w), .pcnt_q(pcnt_w),
    .plim_q(plim_w), .cval0_q(cval0_w)
);

// File: tb/tb_tmr_match_capture.sv
`timescale 1ns/1ps
module tb_tmr_match_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_match_capture dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .match_out(match_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        cap_in = '0;
        bus_we = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int ch);
        @(negedge clk); cap_in[ch] = 1'b1;
        repeat (4) @(negedge clk);
        cap_in[ch] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(5'd0, v);  check("R1 flags", v, 0);
        rd(5'd1, v);  check("R1 ctrl", v, 0);
        rd(5'd2, v);  check("R1 counter", v, 0);
        rd(5'd15, v); check("R1 match-output reg", v, 0);
        rd(5'd16, v); check("R1 count source", v, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 match_out", 32'(match_out), 0);
    endtask

    task automatic t_prescale_and_hold();
        logic [31:0] v;
        do_reset();
        wr(5'd3, 32'd2);
        wr(5'd1, 32'd1);
        edges(31);
        rd(5'd2, v); check("R2 counter after 31 clocks, limit 2", v, 10);
        rd(5'd4, v); check("R2 prescale count", v, 1);
        wr(5'd1, 32'd3);
        edges(3);
        rd(5'd2, v); check("R3 hold zeroes counter", v, 0);
        rd(5'd4, v); check("R3 hold zeroes prescale count", v, 0);
        wr(5'd1, 32'd0);
        wr(5'd2, 32'h55);
        edges(10);
        rd(5'd2, v); check("R3 disabled counter frozen", v, 32'h55);
    endtask

    task automatic t_match_reset();
        logic [31:0] v;
        do_reset();
        wr(5'd6, 32'd4);
        wr(5'd5, 32'h3);
        wr(5'd1, 32'd1);
        edges(12);
        rd(5'd2, v); check("R4 counter wraps with period 5", v, 2);
        rd(5'd0, v); check("R6 match flag 0 set", v, 32'h01);
        check("R6 irq high", 32'(irq), 1);
        wr(5'd1, 32'd0);
        wr(5'd0, 32'h01);
        rd(5'd0, v); check("R6 write-one clears flag", v, 0);
        check("R6 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_match_stop();
        logic [31:0] v;
        do_reset();
        wr(5'd7, 32'd6);
        wr(5'd5, 32'h20);
        wr(5'd1, 32'd1);
        edges(20);
        rd(5'd2, v); check("R5 counter stops at match", v, 6);
        rd(5'd1, v); check("R5 enable cleared by stop", v, 0);
    endtask

    task automatic t_ext_match();
        logic [31:0] v;
        do_reset();
        wr(5'd6, 32'd4);
        wr(5'd7, 32'd2);
        wr(5'd8, 32'd3);
        wr(5'd9, 32'd1);
        wr(5'd5, 32'h2);
        // levels 1100, codes ch0 toggle, ch1 high, ch2 low, ch3 keep
        wr(5'd15, 32'h1BC);
        check("R7 preset levels", 32'(match_out), 32'hC);
        wr(5'd1, 32'd1);
        edges(7);
        check("R7 keep/high/low/toggle after one wrap", 32'(match_out), 32'hB);
        rd(5'd0, v); check("R6 no flags without interrupt bits", v, 0);
        edges(3);
        check("R7 second toggle", 32'(match_out), 32'hA);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        do_reset();
        wr(5'd10, 32'h15);
        wr(5'd2, 32'h1234);
        pulse(0);
        rd(5'd11, v); check("R8 rising capture value", v, 32'h1234);
        rd(5'd0, v);  check("R8 capture flag 4", v, 32'h10);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd(5'd12, v); check("R8 rising ignored on falling-only channel", v, 0);
        wr(5'd2, 32'h777);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd(5'd12, v); check("R8 falling capture value", v, 32'h777);
        rd(5'd0, v);  check("R8 no flag without capture interrupt bit", v, 32'h10);
        check("R6 irq from capture flag", 32'(irq), 1);
        wr(5'd0, 32'hFF);
        rd(5'd0, v);  check("R6 all-ones write clears all", v, 0);
    endtask

    task automatic t_count_edges();
        logic [31:0] v;
        do_reset();
        wr(5'd16, 32'h9);
        wr(5'd1, 32'd1);
        for (int i = 0; i < 5; i++) pulse(2);
        rd(5'd2, v); check("R9 rising edges counted", v, 5);
        pulse(0); pulse(0);
        rd(5'd2, v); check("R9 other input ignored", v, 5);
        wr(5'd16, 32'hB);
        wr(5'd2, 32'd0);
        for (int i = 0; i < 3; i++) pulse(2);
        rd(5'd2, v); check("R9 both edges counted", v, 6);
        wr(5'd16, 32'hA);
        wr(5'd2, 32'd0);
        for (int i = 0; i < 2; i++) pulse(2);
        rd(5'd2, v); check("R9 falling edges counted", v, 2);
        rd(5'd4, v); check("R9 prescale bypassed", v, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_prescale_and_hold();
        t_match_reset();
        t_match_stop();
        t_ext_match();
        t_capture();
        t_count_edges();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end
endmodule